// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped cache on its refill path. It holds only lines that the main cache threw out while handling a miss. When the main cache misses, it presents the missing block address to this buffer, together with the line it is about to displace. The buffer is searched before anything goes to the next memory level.

On a victim hit the two lines trade places. The buffer hands the found line, with its dirty bit, to the main cache. In the same handshake cycle it takes the displaced main-cache line into the freed slot. On a victim miss it raises a forward strobe so that the next level can be asked for the block, and it files the displaced line. That filing may push a least recently used entry out. A dirty entry pushed out leaves on a writeback port, and a clean one is discarded.

Control is a three-state machine. `ST_IDLE` accepts a request (IDLE→PROBE when `req_valid` is high). `ST_PROBE` is the result cycle. It returns to idle after a miss (PROBE→IDLE, with insert and forward) and moves on after a hit (PROBE→SWAP). `ST_SWAP` presents the found line until `swap_ack` (SWAP→IDLE, exchange done).

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1 and `rsp_valid`, `fwd_valid`, `swap_valid` and `wb_valid` are 0. A first lookup therefore misses.
- R2: `rsp_valid` is high for exactly the one cycle after a request is accepted (`req_valid` and `req_ready` at a clock edge). `req_ready` stays low from that result cycle until the request has been fully handled.
- R3: On a victim miss, the result cycle shows `rsp_hit`=0 and `fwd_valid`=1, with `fwd_addr` equal to the requested block address. On a hit, `fwd_valid` stays 0.
- R4: On a miss with `disp_valid`=1, the displaced line (address, data, dirty) is stored. A later lookup of that address hits and returns the same data and dirty bit.
- R5: On a hit, `swap_valid` rises in the cycle after the result cycle. It presents the stored data and dirty bit, and holds them unchanged until the cycle in which `swap_ack` is 1.
- R6: The swap completes at the edge where `swap_valid` and `swap_ack` are both 1. The found address is then gone from the buffer, and the displaced line, with its own dirty bit, occupies the freed slot.
- R7: While a slot is free, an insert uses the lowest-numbered free slot and produces no writeback.
- R8: When all slots are valid, an insert replaces the entry whose last insert or swap-in is oldest. Lookups and misses do not change this order.
- R9: When a replacement pushes out a dirty entry, `wb_valid` is 1 in the result cycle, with that entry's address and data on `wb_addr`/`wb_data`. A clean entry is dropped with `wb_valid`=0.
- R10: With `disp_valid`=0, a miss stores nothing and writes nothing back. A hit frees the found slot without filling it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Main-cache miss presented for search |
| req_ready | output | 1 | Buffer idle and able to accept a request |
| req_addr | input | AW | Block address being searched |
| disp_valid | input | 1 | A line is being displaced from the main cache |
| disp_addr | input | AW | Block address of the displaced line |
| disp_data | input | DW | Data of the displaced line |
| disp_dirty | input | 1 | Dirty bit of the displaced line |
| rsp_valid | output | 1 | Result cycle of the search |
| rsp_hit | output | 1 | Search found the block |
| fwd_valid | output | 1 | Request must go to the next level |
| fwd_addr | output | AW | Address to request from the next level |
| swap_valid | output | 1 | Found line offered to the main cache |
| swap_data | output | DW | Data of the found line |
| swap_dirty | output | 1 | Dirty bit of the found line |
| swap_ack | input | 1 | Main cache takes the line; exchange completes |
| wb_valid | output | 1 | Dirty entry pushed out, must be written back |
| wb_addr | output | AW | Address of the pushed-out line |
| wb_data | output | DW | Data of the pushed-out line |

## Verification
The hit flag, the forward strobe and the writeback fields are all due in the single cycle after the accepting edge. The bench drives each request at a falling edge and reads these results at the next falling edge, one register stage later. The swap offer is due one cycle after that, and the bench checks it at every falling edge until it raises `swap_ack`. It also checks that the offer does not change while the acknowledge is held back. The storage effects of an insert or a swap become visible only through later lookups. A reference model of slots and recency stamps, kept in bench functions, predicts the hit, the data and the writeback for every random or directed request.

// File: rtl/vb_pkg.sv
package vb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SWAP  = 2'd2
    } vb_state_e;
endpackage

// File: rtl/vb_match.sv
// Parallel tag comparison plus free-slot search.
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int IW = 2
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx,
    output logic                 free_any,
    output logic [IW-1:0]        free_idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit      = |eq;
        free_any = ~&vld;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IW'(i);
            if (!vld[i]) free_idx = IW'(i);
        end
    end
endmodule

// File: rtl/vb_age_lru.sv
// Recency ranks kept as a permutation: 0 = newest, N-1 = oldest.
module vb_age_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    logic [N-1:0][IW-1:0] rank;
    logic [IW-1:0]        touched_rank;

    assign touched_rank = rank[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx) rank[i] <= '0;
                else if (rank[i] < touched_rank) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (rank[i] == IW'(N - 1)) lru_idx = IW'(i);
        end
    end
endmodule

// File: rtl/vb_ctrl.sv
// Request sequencing: idle -> probe -> (swap) -> idle.
module vb_ctrl
    import vb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      hit,
    input  logic      swap_ack,
    output vb_state_e state,
    output logic      accept,
    output logic      req_ready,
    output logic      probe,
    output logic      swap_valid,
    output logic      swap_done
);
    vb_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_PROBE;
            ST_PROBE: nxt = hit ? ST_SWAP : ST_IDLE;
            ST_SWAP:  if (swap_ack) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        probe      = 1'b0;
        swap_valid = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready  = 1'b1;
            ST_PROBE: probe      = 1'b1;
            ST_SWAP:  swap_valid = 1'b1;
            default:  req_ready  = 1'b0;
        endcase
        accept    = req_ready && req_valid;
        swap_done = swap_valid && swap_ack;
    end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 26,
    parameter int DW      = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          disp_valid,
    input  logic [AW-1:0] disp_addr,
    input  logic [DW-1:0] disp_data,
    input  logic          disp_dirty,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic          fwd_valid,
    output logic [AW-1:0] fwd_addr,
    output logic          swap_valid,
    output logic [DW-1:0] swap_data,
    output logic          swap_dirty,
    input  logic          swap_ack,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // storage
    logic [ENTRIES-1:0]         ent_vld;
    logic [ENTRIES-1:0][AW-1:0] ent_tag;
    logic [ENTRIES-1:0][DW-1:0] ent_dat;
    logic [ENTRIES-1:0]         ent_dty;

    // captured request
    logic [AW-1:0] q_addr;
    logic          q_dvld;
    logic [AW-1:0] q_daddr;
    logic [DW-1:0] q_ddata;
    logic          q_ddty;
    logic [IW-1:0] q_hidx;

    vb_state_e     state;
    logic          accept, probe, swap_done;
    logic          hit, free_any;
    logic [IW-1:0] hit_idx, free_idx, lru_idx;
    logic          ins_en, touch;
    logic [IW-1:0] ins_idx, touch_idx;

    vb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .hit        (hit),
        .swap_ack   (swap_ack),
        .state      (state),
        .accept     (accept),
        .req_ready  (req_ready),
        .probe      (probe),
        .swap_valid (swap_valid),
        .swap_done  (swap_done)
    );

    vb_match #(.N(ENTRIES), .AW(AW), .IW(IW)) u_match (
        .vld      (ent_vld),
        .tags     (ent_tag),
        .key      (q_addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    vb_age_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    // miss path: file the displaced line
    assign ins_en  = probe && !hit && q_dvld;
    assign ins_idx = free_any ? free_idx : lru_idx;
    assign touch     = ins_en || swap_done;
    assign touch_idx = swap_done ? q_hidx : ins_idx;

    // result-cycle outputs
    assign rsp_valid = probe;
    assign rsp_hit   = probe && hit;
    assign fwd_valid = probe && !hit;
    assign fwd_addr  = q_addr;
    assign wb_valid  = ins_en && !free_any && ent_dty[lru_idx];
    assign wb_addr   = ent_tag[lru_idx];
    assign wb_data   = ent_dat[lru_idx];

    // swap outputs (entry untouched while waiting)
    assign swap_data  = ent_dat[q_hidx];
    assign swap_dirty = ent_dty[q_hidx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_dvld  <= 1'b0;
            q_daddr <= '0;
            q_ddata <= '0;
            q_ddty  <= 1'b0;
            q_hidx  <= '0;
        end else begin
            if (accept) begin
                q_addr  <= req_addr;
                q_dvld  <= disp_valid;
                q_daddr <= disp_addr;
                q_ddata <= disp_data;
                q_ddty  <= disp_dirty;
            end
            if (probe) q_hidx <= hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_tag <= '0;
            ent_dat <= '0;
            ent_dty <= '0;
        end else if (ins_en) begin
            ent_vld[ins_idx] <= 1'b1;
            ent_tag[ins_idx] <= q_daddr;
            ent_dat[ins_idx] <= q_ddata;
            ent_dty[ins_idx] <= q_ddty;
        end else if (swap_done) begin
            ent_vld[q_hidx] <= q_dvld;
            ent_tag[q_hidx] <= q_daddr;
            ent_dat[q_hidx] <= q_ddata;
            ent_dty[q_hidx] <= q_ddty;
        end
    end
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int AW = 26,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic          fwd_valid,
    input logic [AW-1:0] fwd_addr,
    input logic          swap_valid,
    input logic [DW-1:0] swap_data,
    input logic          swap_dirty,
    input logic          swap_ack,
    input logic          wb_valid
);
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R2
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || swap_valid) |-> !req_ready); // R2
    AST_FWD_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (rsp_valid && !rsp_hit)); // R3
    AST_FWD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_addr == $past(req_addr))); // R3
    AST_SWAP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |=> swap_valid); // R5
    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_valid && !swap_ack) |=> (swap_valid && $stable(swap_data) && $stable(swap_dirty))); // R5
    AST_SWAP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_valid && swap_ack) |=> !swap_valid); // R6
    AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> fwd_valid); // R9
endmodule

bind victim_buffer vb_checker #(.AW(AW), .DW(DW)) u_vb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .fwd_valid  (fwd_valid),
    .fwd_addr   (fwd_addr),
    .swap_valid (swap_valid),
    .swap_data  (swap_data),
    .swap_dirty (swap_dirty),
    .swap_ack   (swap_ack),
    .wb_valid   (wb_valid)
);

// File: tb/victim_buffer_tb_top.sv
module victim_buffer_tb_top;
    localparam int N  = 4;
    localparam int AW = 26;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          disp_valid = 1'b0;
    logic [AW-1:0] disp_addr = '0;
    logic [DW-1:0] disp_data = '0;
    logic          disp_dirty = 1'b0;
    logic          rsp_valid, rsp_hit, fwd_valid;
    logic [AW-1:0] fwd_addr;
    logic          swap_valid, swap_dirty;
    logic [DW-1:0] swap_data;
    logic          swap_ack = 1'b0;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    always #5 clk = ~clk;

    victim_buffer #(.ENTRIES(N), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .disp_valid(disp_valid), .disp_addr(disp_addr),
        .disp_data(disp_data), .disp_dirty(disp_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .swap_valid(swap_valid), .swap_data(swap_data),
        .swap_dirty(swap_dirty), .swap_ack(swap_ack),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model
    bit          m_vld [N];
    logic [AW-1:0] m_tag [N];
    logic [DW-1:0] m_dat [N];
    bit          m_dty [N];
    int          m_stamp [N];
    int          stamp_ctr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_pick();
        int best;
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        best = 0;
        for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[best]) best = i;
        return best;
    endfunction

    function automatic bit m_full();
        for (int i = 0; i < N; i++) if (!m_vld[i]) return 1'b0;
        return 1'b1;
    endfunction

    // one complete request with model update and checks
    task automatic do_req(input logic [AW-1:0] a, input bit dv,
                          input logic [AW-1:0] da, input logic [DW-1:0] dd,
                          input bit ddt, input int ack_delay);
        int hidx, slot;
        bit exp_wb, full;
        logic [AW-1:0] exp_wba;
        logic [DW-1:0] exp_wbd, exp_sd;
        bit exp_sdt;
        hidx = m_find(a);
        full = m_full();
        slot = m_pick();
        exp_wb = 1'b0; exp_wba = '0; exp_wbd = '0; exp_sd = '0; exp_sdt = 1'b0;
        if (hidx < 0 && dv && full && m_dty[slot]) begin
            exp_wb = 1'b1; exp_wba = m_tag[slot]; exp_wbd = m_dat[slot];
        end
        if (hidx >= 0) begin
            exp_sd = m_dat[hidx]; exp_sdt = m_dty[hidx];
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a;
        disp_valid = dv; disp_addr = da; disp_data = dd; disp_dirty = ddt;
        @(negedge clk);
        req_valid = 1'b0; disp_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2", "rsp_valid in result cycle", 64'(rsp_valid), 64'd1);
        chk(req_ready == 1'b0, "R2", "ready low while busy", 64'(req_ready), 64'd0);
        chk(rsp_hit == (hidx >= 0), "R4", "hit flag", 64'(rsp_hit), 64'(hidx >= 0));
        chk(fwd_valid == (hidx < 0), "R3", "forward strobe", 64'(fwd_valid), 64'(hidx < 0));
        if (hidx < 0)
            chk(fwd_addr == a, "R3", "forward address", 64'(fwd_addr), 64'(a));
        chk(wb_valid == exp_wb, "R9", "writeback strobe", 64'(wb_valid), 64'(exp_wb));
        if (exp_wb) begin
            chk(wb_addr == exp_wba, "R9", "writeback address", 64'(wb_addr), 64'(exp_wba));
            chk(wb_data == exp_wbd, "R9", "writeback data", wb_data, exp_wbd);
        end
        if (hidx < 0) begin
            if (dv) begin
                m_vld[slot] = 1'b1; m_tag[slot] = da; m_dat[slot] = dd;
                m_dty[slot] = ddt; m_stamp[slot] = ++stamp_ctr;
            end
        end else begin
            @(negedge clk);
            chk(swap_valid == 1'b1, "R5", "swap offered", 64'(swap_valid), 64'd1);
            chk(swap_data == exp_sd, "R5", "swap data", swap_data, exp_sd);
            chk(swap_dirty == exp_sdt, "R5", "swap dirty", 64'(swap_dirty), 64'(exp_sdt));
            for (int d = 0; d < ack_delay; d++) begin
                @(negedge clk);
                chk(swap_valid == 1'b1 && swap_data == exp_sd, "R5", "swap held",
                    swap_data, exp_sd);
            end
            swap_ack = 1'b1;
            @(negedge clk);
            swap_ack = 1'b0;
            chk(swap_valid == 1'b0, "R6", "swap closed", 64'(swap_valid), 64'd0);
            m_vld[hidx] = dv; m_tag[hidx] = da; m_dat[hidx] = dd;
            m_dty[hidx] = ddt; m_stamp[hidx] = ++stamp_ctr;
        end
    endtask

    function automatic logic [DW-1:0] rdat();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [AW-1:0] paddr(input int k);
        return AW'(32'h100 + k);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0; m_dty[i] = 1'b0; m_stamp[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0 && fwd_valid == 1'b0, "R1", "no result after reset",
            64'({rsp_valid, fwd_valid}), 64'd0);
        chk(swap_valid == 1'b0 && wb_valid == 1'b0, "R1", "no swap/wb after reset",
            64'({swap_valid, wb_valid}), 64'd0);
        chk(m_find(paddr(0)) < 0, "R1", "model empty", 64'd0, 64'd0);
        do_req(paddr(0), 1'b0, '0, '0, 1'b0, 0);                 // R1, R10 miss with nothing to file
        do_req(paddr(0), 1'b0, '0, '0, 1'b0, 0);                 // R10 still absent
        // R7: fill free slots, clean and dirty mix, no writeback
        do_req(paddr(9), 1'b1, paddr(1), 64'h1111, 1'b0, 0);
        do_req(paddr(9), 1'b1, paddr(2), 64'h2222, 1'b1, 0);
        do_req(paddr(9), 1'b1, paddr(3), 64'h3333, 1'b1, 0);
        do_req(paddr(9), 1'b1, paddr(4), 64'h4444, 1'b0, 0);
        // R4: hit returns stored data; R6 swap with delayed ack
        do_req(paddr(2), 1'b1, paddr(5), 64'h5555, 1'b0, 3);
        do_req(paddr(2), 1'b0, '0, '0, 1'b0, 0);                 // R6 found line gone
        do_req(paddr(5), 1'b1, paddr(2), 64'h2223, 1'b1, 0);     // R6 displaced now present
        // R8/R9: full buffer, oldest is paddr(1) clean -> dropped
        do_req(paddr(9), 1'b1, paddr(6), 64'h6666, 1'b1, 0);
        // oldest now paddr(3) dirty -> writeback
        do_req(paddr(9), 1'b1, paddr(7), 64'h7777, 1'b0, 0);
        // R10: hit with no displaced line frees the slot
        do_req(paddr(4), 1'b0, '0, '0, 1'b0, 1);
        do_req(paddr(9), 1'b1, paddr(8), 64'h8888, 1'b0, 0);     // R7 refills freed slot

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int ra, dk, tries;
            bit dv;
            ra = int'($urandom_range(0, 9));
            dv = ($urandom_range(0, 7) != 0);
            dk = int'($urandom_range(0, 9));
            tries = 0;
            while ((dk == ra || m_find(paddr(dk)) >= 0) && tries < 40) begin
                dk = int'($urandom_range(0, 9));
                tries++;
            end
            if (dk == ra || m_find(paddr(dk)) >= 0) dv = 1'b0;
            do_req(paddr(ra), dv, paddr(dk), rdat(), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 2)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule